// File: doc/BRIEF.md
# Approximate Leading-One Logarithm Unit

This block turns an unsigned 32-bit operand into a Mitchell-style binary logarithm. That is the form used in a logarithmic number system, where a product becomes the sum of two logarithms. The logarithm has two parts:

- an integer part, which is the position of the most significant set bit;
- a fractional part, which is the bits below that position, left-justified into an F-bit field. Bits that do not fit are truncated.

Only the upper W-D bit positions are searched exactly. When the leading one lies inside the low D positions, the integer part is estimated instead. A build-time parameter picks the estimation scheme:

- **Fixed scheme:** one constant, D/2, is used for every position in the low region.
- **Field scheme:** the low region is split into equal fields. The highest non-empty field is selected, and its midpoint is used.

Both schemes make signed errors, which tend to cancel when many results are summed. A per-operation pre-scale request removes the error instead. It moves a small operand up by D bits before the search and then takes D back off the integer part. The computation sits behind a one-cycle registered stage with a valid flag.

Top module: `alog_lod_unit`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. While `rst` is high, `out_valid`, `out_zero`, `out_int` and `out_frac` are all 0.
- R2: For an operand of at least 2^D (default D=8), `out_int` is the exact bit position of the most significant set bit, with bit 0 as position 0.
- R3: `out_frac` equals floor((x mod 2^k) * 2^F / 2^k). Here k is the unscaled integer position the unit reports, and F defaults to 16. This means the bits below position k, left-justified, with the excess truncated.
- R4: Fixed scheme, for 0 < x < 2^D and no pre-scale: `out_int` is D/2, which is 4 by default, whatever the operand.
- R5: Field scheme, for 0 < x < 2^D and no pre-scale: let G = D/NFIELD (default 4). Field k holds positions kG to kG+G-1, numbered from the LSB. `out_int` is kG+G/2 for the field k that holds the leading one. By default this is 2 or 6.
- R6: For 0 < x < 2^D without pre-scale, |`out_int` − exact position| is at most D/2 in the fixed scheme and at most G/2 in the field scheme. Over a sweep of the low positions the error takes both signs.
- R7: With `in_scale`=1 and 0 < x < 2^D, `out_int` is the exact position and `out_frac` follows R3 with that exact position.
- R8: With an operand of at least 2^D, `in_scale` has no effect on either output.
- R9: A zero operand sets `out_zero`=1 and drives `out_int`=0 and `out_frac`=0. A nonzero operand gives `out_zero`=0.
- R10: A cycle with `in_valid`=0 leaves `out_zero`, `out_int` and `out_frac` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | W | Unsigned operand |
| in_scale | input | 1 | Request pre-scaling of a small operand |
| out_valid | output | 1 | Result present |
| out_zero | output | 1 | Operand was zero |
| out_int | output | clog2(W) | Integer part of the logarithm |
| out_frac | output | F | Fractional part of the logarithm |

## Verification
The bench drives single-bit operands at every position, including exactly 2^D and the top bit. These show whether the exact search starts at the right boundary and whether each field picks its own midpoint. Dense low operands such as 0xFF and 0x0F are compared with sparse ones at the same leading position. This separates a field choice made on the leading one from one made on lower bits, and exercises the truncation of the fraction. The same small operands are sent with and without pre-scale, and large operands with it, which shows the correction of the integer part and that the request is ignored above 2^D. Zero operands, idle cycles and a long pseudo-random mix are checked against a behavioural model every clock.

// File: rtl/alog_pkg.sv
package alog_pkg;
  // How positions inside the low region are estimated
  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_FIELD = 1'b1
  } mode_e;
endpackage

// File: rtl/alog_lod_exact.sv
// Exact priority search over the upper part of the operand.
module alog_lod_exact #(
  parameter int WIDTH = 24,
  parameter int IDXW  = 5
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  always_comb begin
    if (found) begin
      p_found_bit_r2: assert (vec[idx]);
    end
  end
endmodule

// File: rtl/alog_lod_coarse.sv
// Position estimate for a leading one inside the low D bits.
module alog_lod_coarse #(
  parameter int             D      = 8,
  parameter int             NFIELD = 2,
  parameter alog_pkg::mode_e MODE  = alog_pkg::MODE_FIELD,
  parameter int             PW     = 5
) (
  input  logic [D-1:0]  low,
  output logic [PW-1:0] est
);
  localparam int G = D / NFIELD;

  generate
    if (MODE == alog_pkg::MODE_FIXED) begin : g_fixed
      logic unused_low;
      assign unused_low = ^low;
      assign est = PW'(D / 2);
    end else begin : g_field
      logic [NFIELD-1:0] field_any;
      for (genvar k = 0; k < NFIELD; k++) begin : g_any
        assign field_any[k] = |low[k*G +: G];
      end
      always_comb begin
        est = '0;
        for (int k = 0; k < NFIELD; k++) begin
          if (field_any[k]) est = PW'(k * G + G / 2);
        end
      end
    end
  endgenerate

  always_comb begin
    p_est_range_r5: assert (est < PW'(D));
  end
endmodule

// File: rtl/alog_frac_align.sv
// Left-justifies the bits below position pos into an F-bit fraction (F <= WIDTH).
module alog_frac_align #(
  parameter int WIDTH = 32,
  parameter int F     = 16,
  parameter int PW    = 5
) (
  input  logic [WIDTH-1:0] val,
  input  logic [PW-1:0]    pos,
  output logic [F-1:0]     frac
);
  localparam int SW = $clog2(WIDTH) + 1;

  logic [SW-1:0]    sh;
  logic [WIDTH-1:0] shifted;

  assign sh      = SW'(WIDTH) - SW'(pos);
  assign shifted = val << sh;
  assign frac    = shifted[WIDTH-1 -: F];
endmodule

// File: rtl/alog_lod_unit.sv
module alog_lod_unit #(
  parameter int              W      = 32,
  parameter int              D      = 8,
  parameter int              NFIELD = 2,
  parameter int              F      = 16,
  parameter alog_pkg::mode_e MODE   = alog_pkg::MODE_FIELD,
  localparam int             IW     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          in_scale,
  output logic          out_valid,
  output logic          out_zero,
  output logic [IW-1:0] out_int,
  output logic [F-1:0]  out_frac
);
  localparam int HW = W - D;

  logic          upper_zero, nonzero, do_scale;
  logic [W-1:0]  det;
  logic          hi_found;
  logic [IW-1:0] hi_idx, lo_est, pos, int_c;
  logic [F-1:0]  frac_c;

  assign upper_zero = ~|in_data[W-1:D];
  assign nonzero    = |in_data;
  assign do_scale   = in_scale & upper_zero & nonzero;
  assign det        = do_scale ? (in_data << D) : in_data;

  alog_lod_exact #(.WIDTH(HW), .IDXW(IW)) u_hi (
    .vec  (det[W-1:D]),
    .found(hi_found),
    .idx  (hi_idx)
  );

  alog_lod_coarse #(.D(D), .NFIELD(NFIELD), .MODE(MODE), .PW(IW)) u_lo (
    .low(det[D-1:0]),
    .est(lo_est)
  );

  assign pos   = hi_found ? (hi_idx + IW'(D)) : lo_est;
  assign int_c = do_scale ? (pos - IW'(D)) : pos;

  alog_frac_align #(.WIDTH(W), .F(F), .PW(IW)) u_fr (
    .val (det),
    .pos (pos),
    .frac(frac_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_zero  <= 1'b0;
      out_int   <= '0;
      out_frac  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_zero <= ~nonzero;
        out_int  <= nonzero ? int_c : '0;
        out_frac <= nonzero ? frac_c : '0;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_upper_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && |in_data[W-1:D]) |=> (out_int >= IW'(D)) && !out_zero);
  p_scaled_small_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_scale && nonzero && upper_zero) |=> (out_int < IW'(D)));
  p_zero_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero) |-> (out_int == '0) && (out_frac == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_int) && $stable(out_frac) && $stable(out_zero));
endmodule

// File: tb/alog_lod_unit_bench.sv
module alog_lod_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int D  = 8;
  localparam int NF = 2;
  localparam int F  = 16;
  localparam int IW = 5;
  localparam int G  = D / NF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_scale = 1'b0;
  logic          va, za, vb, zb;
  logic [IW-1:0] ia, ib;
  logic [F-1:0]  fa, fb;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alog_lod_unit #(.W(W), .D(D), .NFIELD(NF), .F(F), .MODE(alog_pkg::MODE_FIELD)) u_alog_lod_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_scale(in_scale),
    .out_valid(va), .out_zero(za), .out_int(ia), .out_frac(fa)
  );

  alog_lod_unit #(.W(W), .D(D), .NFIELD(NF), .F(F), .MODE(alog_pkg::MODE_FIXED)) u_alog_lod_unit_fix (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_scale(in_scale),
    .out_valid(vb), .out_zero(zb), .out_int(ib), .out_frac(fb)
  );

  // expected state of both units
  longint e_valid = 0, e_zero = 0, e_ia = 0, e_fa = 0, e_ib = 0, e_fb = 0;
  int     e_pos = 0;
  bit     e_small = 0;
  string  e_req = "R1";
  bit     seen_pos = 0, seen_neg = 0;

  function automatic int msb_pos(logic [W-1:0] x);
    int p = 0;
    for (int i = 0; i < W; i++) if (x[i]) p = i;
    return p;
  endfunction

  function automatic int ref_int(logic [W-1:0] x, bit s, bit fld);
    int p;
    if (x == '0) return 0;
    p = msb_pos(x);
    if (p >= D || s) return p;
    return fld ? (p / G) * G + G / 2 : D / 2;
  endfunction

  function automatic longint ref_frac(logic [W-1:0] x, int k);
    longint unsigned val;
    val = 64'(x) & ((64'd1 << k) - 64'd1);
    return longint'((val << F) >> k);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [W-1:0] x, bit s, string req);
    int err;
    @(negedge clk);
    chk(e_req, "field valid", longint'(va), e_valid);
    chk(e_req, "fixed valid", longint'(vb), e_valid);
    chk(e_req, "field zero",  longint'(za), e_zero);
    chk(e_req, "fixed zero",  longint'(zb), e_zero);
    chk(e_req, "field int",   longint'(ia), e_ia);
    chk(e_req, "fixed int",   longint'(ib), e_ib);
    chk(e_req, "field frac",  longint'(fa), e_fa);
    chk(e_req, "fixed frac",  longint'(fb), e_fb);
    if (e_valid != 0 && e_small) begin
      err = int'(ia) - e_pos;
      chk("R6", "field error bound", longint'(err <= G/2 && err >= -(G/2)), 1);
      err = int'(ib) - e_pos;
      chk("R6", "fixed error bound", longint'(err <= D/2 && err >= -(D/2)), 1);
      if (err > 0) seen_pos = 1;
      if (err < 0) seen_neg = 1;
    end
    // drive the next operand and compute what it must produce
    in_valid = v; in_data = x; in_scale = s;
    e_valid = v;
    e_req   = req;
    e_small = 0;
    if (v) begin
      e_zero = (x == '0);
      e_ia   = ref_int(x, s, 1'b1);
      e_ib   = ref_int(x, s, 1'b0);
      e_fa   = (x == '0) ? 0 : ref_frac(x, int'(e_ia));
      e_fb   = (x == '0) ? 0 : ref_frac(x, int'(e_ib));
      e_pos  = msb_pos(x);
      e_small = (x != '0) && (x < (1 << D)) && !s;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr = 32'hACE1_2468;
    logic [W-1:0] x;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset valid", longint'(va | vb), 0);
    chk("R1", "reset zero",  longint'(za | zb), 0);
    chk("R1", "reset int",   longint'(ia | ib), 0);
    chk("R1", "reset frac",  longint'(fa | fb), 0);
    rst = 1'b0;

    step(1, 32'h8000_0000, 0, "R2");
    step(1, 32'h0000_0100, 0, "R2");
    step(1, 32'h1234_5678, 0, "R3");
    step(1, 32'h0000_01FF, 0, "R3");
    step(1, 32'h0000_00FF, 0, "R4");
    step(1, 32'h0000_0001, 0, "R4");
    step(1, 32'h0000_0010, 0, "R5");
    step(1, 32'h0000_000F, 0, "R5");
    step(1, 32'h0000_0008, 0, "R5");
    for (int p = 0; p < D; p++) step(1, 32'd1 << p, 0, "R6");
    for (int p = 0; p < D; p++) step(1, (32'd1 << p) | 32'd1, 0, "R6");
    step(1, 32'h0000_0001, 1, "R7");
    step(1, 32'h0000_00FF, 1, "R7");
    step(1, 32'h0000_005A, 1, "R7");
    step(1, 32'h0001_0000, 1, "R8");
    step(1, 32'hFFFF_FFFF, 1, "R8");
    step(1, 32'h0000_0100, 1, "R8");
    step(1, 32'h0000_0000, 0, "R9");
    step(1, 32'h0000_0000, 1, "R9");
    step(1, 32'h0000_0037, 0, "R10");
    step(0, 32'hDEAD_BEEF, 1, "R10");
    step(0, 32'h0000_0000, 0, "R10");
    step(1, 32'h0000_0000, 0, "R9");
    step(0, 32'h0000_0003, 0, "R10");
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      if (i % 3 == 0) x = x & 32'hFF;
      else if (i % 3 == 1) x = x >> (i % 29);
      step(i % 7 != 6, x, lfsr[5], "R3");
    end
    step(0, '0, 0, "R10");
    step(0, '0, 0, "R10");
    chk("R6", "positive error seen", longint'(seen_pos), 1);
    chk("R6", "negative error seen", longint'(seen_neg), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule